// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry-Out

A purely combinational 32-bit shifter that prepares the second operand of an arithmetic or logic operation in a processor datapath. It takes a 32-bit word, a 3-bit shift kind, an 8-bit shift length and the current carry flag. It returns the shifted word, the bit that the flag would take, and a strobe that says whether the flag is to be written.

Five shift kinds are supported: logical left, logical right, arithmetic right, rotate right, and a one-place rotate right through the carry. The length is 8 bits wide, so an amount read from a register can reach 255. Amounts of zero, of exactly 32 and of more than 32 each follow their own rules for the result and for the carry.

The instruction decoder drives a single enable, `flag_en_i`. It is high when the consuming instruction writes flags. The shifter does not decide which instructions may set flags.

Top module: `opnd_shifter`

## Requirements
- R1: Kind codes are 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right, 4 = rotate-through-carry. For kinds 0 to 3 with a length of 0, the result equals the input, the carry output equals `carry_i`, and `carry_we_o` is 0.
- R2: Logical left by n. For n from 1 to 31, the result is the input shifted up by n with zeros filled in, and the carry is input bit 32-n. For n = 32, the result is 0 and the carry is input bit 0. For n > 32, the result and the carry are both 0.
- R3: Logical right by n. For n from 1 to 31, the result is the input shifted down by n with zeros filled in, and the carry is input bit n-1. For n = 32, the result is 0 and the carry is input bit 31. For n > 32, the result and the carry are both 0.
- R4: Arithmetic right by n. For n from 1 to 31, the top n result bits copy input bit 31 and the carry is input bit n-1. For n of 32 or more, every result bit and the carry equal input bit 31.
- R5: Rotate right by a nonzero n uses n modulo 32. The bits shifted out of the bottom wrap into the top, and the carry equals result bit 31. When n is a nonzero multiple of 32, the result equals the input and the carry is input bit 31.
- R6: Rotate-through-carry ignores the length. Result bit 31 is `carry_i`, result bits 30..0 are input bits 31..1, and the carry is input bit 0.
- R7: `carry_we_o` is 1 only when `flag_en_i` is 1 and the shift is real: either the kind is 4, or the kind is 0 to 3 with a nonzero length.
- R8: Kind codes 5 to 7 pass the input through unchanged, give the carry output `carry_i`, and hold `carry_we_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 32 | Word to be shifted |
| kind_i | input | 3 | Shift kind code |
| amt_i | input | 8 | Shift length |
| carry_i | input | 1 | Current carry flag |
| flag_en_i | input | 1 | Consuming instruction sets flags |
| res_o | output | 32 | Shifted word |
| carry_o | output | 1 | Carry value produced by the shift |
| carry_we_o | output | 1 | Write strobe for the carry flag |

## Verification
The bench sweeps every kind code over the lengths 0 to 40, 63, 64, 128 and 255. Each is tried with fixed bit patterns and random words, with both carry-in values and both enable values. Expected values come from a bit-by-bit model.

The sweep targets the boundaries where a design is most likely to be wrong:
- At length 32, a design that treats 32 like a larger length would drop the carry bit.
- At length 33, a design that truncates the length to five bits would wrap back to a one-place shift.
- For a rotate by 32, 64 or 128, a design that treats it as a zero-length rotate would pass `carry_i` instead of bit 31.
- At length 0, a design that raises the write strobe would corrupt the flag.
- With the top bit set, an arithmetic shift that filled with zeros would give the wrong result.

// File: rtl/opnd_shifter.sv
module opnd_shifter #(
  parameter int W = 32
) (
  input  logic [31:0] opnd_i,
  input  logic [2:0]  kind_i,
  input  logic [7:0]  amt_i,
  input  logic        carry_i,
  input  logic        flag_en_i,
  output logic [31:0] res_o,
  output logic        carry_o,
  output logic        carry_we_o
);
  localparam logic [2:0] K_LSL = 3'd0, K_LSR = 3'd1, K_ASR = 3'd2,
                         K_ROR = 3'd3, K_RRX = 3'd4;
  localparam int DW = 2 * W;

  logic          amt_zero;
  logic [5:0]    asr_amt;
  logic [DW-1:0] lsl_w, lsr_w, asr_w, ror_w;

  assign amt_zero = (amt_i == 8'd0);
  assign asr_amt  = (amt_i >= 8'd32) ? 6'd32 : amt_i[5:0];
  assign lsl_w    = {32'b0, opnd_i} << amt_i;
  assign lsr_w    = {opnd_i, 32'b0} >> amt_i;
  assign asr_w    = $signed({opnd_i, 32'b0}) >>> asr_amt;
  assign ror_w    = {opnd_i, opnd_i} >> amt_i[4:0];

  always_comb begin
    res_o      = opnd_i;
    carry_o    = carry_i;
    carry_we_o = 1'b0;
    unique case (kind_i)
      K_LSL: if (!amt_zero) begin
        res_o = lsl_w[31:0];  carry_o = lsl_w[32];
      end
      K_LSR: if (!amt_zero) begin
        res_o = lsr_w[63:32]; carry_o = lsr_w[31];
      end
      K_ASR: if (!amt_zero) begin
        res_o = asr_w[63:32]; carry_o = asr_w[31];
      end
      K_ROR: if (!amt_zero) begin
        res_o = ror_w[31:0];  carry_o = ror_w[31];
      end
      K_RRX: begin
        res_o = {carry_i, opnd_i[31:1]}; carry_o = opnd_i[0];
      end
      default: ;
    endcase
    if (kind_i == K_RRX || (kind_i < K_RRX && !amt_zero))
      carry_we_o = flag_en_i;
  end

  always_comb begin
    // R1
    a_r1_zero_passthru: assert (!(kind_i < K_RRX && amt_zero) ||
                                (res_o == opnd_i && !carry_we_o)) else $error("a_r1_zero_passthru");
    // R7
    a_r7_we_needs_en: assert (!carry_we_o || flag_en_i) else $error("a_r7_we_needs_en");
    // R4
    a_r4_asr_sat: assert (!(kind_i == K_ASR && amt_i >= 8'd32) ||
                          (res_o == {32{opnd_i[31]}} && carry_o == opnd_i[31])) else $error("a_r4_asr_sat");
    // R6
    a_r6_rrx_fill: assert (kind_i != K_RRX ||
                           (res_o[31] == carry_i && carry_o == opnd_i[0])) else $error("a_r6_rrx_fill");
    // R2 R3
    a_r2_r3_overlong: assert (!((kind_i == K_LSL || kind_i == K_LSR) && amt_i > 8'd32) ||
                              (res_o == 32'd0 && !carry_o)) else $error("a_r2_r3_overlong");
    // R5
    a_r5_ror_popcount: assert (kind_i != K_ROR ||
                               $countones(res_o) == $countones(opnd_i)) else $error("a_r5_ror_popcount");
    // R8
    a_r8_bad_kind: assert (kind_i <= K_RRX ||
                           (res_o == opnd_i && carry_o == carry_i && !carry_we_o)) else $error("a_r8_bad_kind");
  end
endmodule

// File: tb/opnd_shifter_bench.sv
module opnd_shifter_bench;
  logic        clk = 1'b0;
  logic [31:0] opnd;
  logic [2:0]  kind;
  logic [7:0]  amt;
  logic        cin, fen;
  logic [31:0] res;
  logic        cout, cwe;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  opnd_shifter u_opnd_shifter (
    .opnd_i(opnd), .kind_i(kind), .amt_i(amt), .carry_i(cin), .flag_en_i(fen),
    .res_o(res), .carry_o(cout), .carry_we_o(cwe)
  );

  function automatic string tag_of(input logic [2:0] k, input logic [7:0] a);
    if (k > 3'd4) return "R8";
    if (k == 3'd4) return "R6";
    if (a == 8'd0) return "R1";
    case (k)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic run(input logic [2:0] k, input logic [7:0] a, input logic [31:0] op,
                     input logic ci, input logic fe);
    logic [31:0] er; logic ec, ew; int n, m;
    @(negedge clk);
    kind = k; amt = a; opnd = op; cin = ci; fen = fe;
    n = a; er = op; ec = ci; ew = 1'b0;
    if (k == 3'd4) begin
      for (int i = 0; i < 31; i++) er[i] = op[i+1];
      er[31] = ci; ec = op[0]; ew = fe;
    end else if (k < 3'd4 && n != 0) begin
      ew = fe;
      case (k)
        3'd0: begin
          for (int i = 0; i < 32; i++) er[i] = (i - n >= 0) ? op[i-n] : 1'b0;
          ec = (32 - n >= 0) ? op[32-n] : 1'b0;
        end
        3'd1: begin
          for (int i = 0; i < 32; i++) er[i] = (i + n <= 31) ? op[i+n] : 1'b0;
          ec = (n - 1 <= 31) ? op[n-1] : 1'b0;
        end
        3'd2: begin
          m = (n > 32) ? 32 : n;
          for (int i = 0; i < 32; i++) er[i] = (i + m <= 31) ? op[i+m] : op[31];
          ec = op[m-1];
        end
        default: begin
          m = n % 32;
          for (int i = 0; i < 32; i++) er[i] = op[(i+m)%32];
          ec = er[31];
        end
      endcase
    end
    #2;
    checks++;
    if (res !== er || cout !== ec) begin
      fails++;
      $display("FAIL %s kind=%0d amt=%0d op=%h cin=%0b: res=%h cout=%0b expected res=%h cout=%0b",
               tag_of(k, a), k, a, op, ci, res, cout, er, ec);
    end
    checks++;
    if (cwe !== ew) begin
      fails++;
      $display("FAIL R7 kind=%0d amt=%0d en=%0b: carry_we=%0b expected %0b", k, a, fe, cwe, ew);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired: done=0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] pats [10];
    logic [7:0]  amts [49];
    pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'h8000_0000;
    pats[3] = 32'h0000_0001; pats[4] = 32'h7FFF_FFFF; pats[5] = 32'hA5C3_3C5A;
    for (int i = 6; i < 10; i++) pats[i] = $urandom;
    for (int i = 0; i <= 40; i++) amts[i] = 8'(i);
    amts[41] = 8'd63; amts[42] = 8'd64; amts[43] = 8'd96; amts[44] = 8'd128;
    amts[45] = 8'd255; amts[46] = 8'd160; amts[47] = 8'd224; amts[48] = 8'd65;
    // reset-like idle state: zero word, no shift, no flag write (R1)
    run(3'd0, 8'd0, 32'd0, 1'b0, 1'b0);
    for (int k = 0; k < 8; k++)
      for (int a = 0; a < 49; a++)
        for (int p = 0; p < 10; p++)
          for (int c = 0; c < 4; c++)
            run(3'(k), amts[a], pats[p], c[0], c[1]);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule